// File: doc/BRIEF.md
# IPI and Mailbox Send Command Decoder

This block takes one 64-bit send command at a time and turns it into the register writes that a destination core must receive. There are three kinds of command. An interrupt send sets one pending-vector bit at the destination. A mailbox send writes one word of the destination's eight-word mailbox. A free-address send writes any 16-bit location of the destination's register space. Every command carries the destination core number, a 4-bit byte-keep mask and a 32-bit payload in the same 64-bit word.

For the mailbox and free-address kinds, a nonzero keep mask turns the command into a read-modify-write. The block first reads the old word over its transaction port. It then writes back a word in which the kept bytes hold their old value and the other bytes take the payload. A zero mask gives a single direct write. Commands aimed at a core number outside the configured range, and mailbox or free-address commands that did not arrive as full 64-bit accesses, are dropped. For a dropped command the block raises a drop event and a done pulse and sends nothing on the transaction port.

The controller has four states. IDLE waits for a command. RD_REQ presents a read request until it is accepted. RD_WAIT waits for the returned data. WR_REQ presents the write until it is accepted. The transitions are: IDLE to RD_REQ (accepted command, nonzero keep mask), IDLE to WR_REQ (accepted command, zero mask or interrupt send), IDLE to IDLE (no command, or a dropped command), RD_REQ to RD_WAIT (read accepted), RD_WAIT to WR_REQ (read data returned), and WR_REQ to IDLE (write accepted).

Top module: `ipi_send_engine`

## Requirements
- R1: After reset, busy, done, drop_evt and req_valid are all 0.
- R2: A command whose core field (bits 25:16) is at or above NUM_CORES, or whose kind code is 3, produces no request. It raises done and drop_evt together for one cycle, in the cycle after acceptance.
- R3: An interrupt send (kind 0) issues one write with no read, to address 0x1008. The write data has only bit n set, where n is command bits 4:0. The keep mask is ignored.
- R4: A mailbox send (kind 1) targets address 0x1020 + (command & 0x1C). All other low command bits are ignored.
- R5: A free-address send (kind 2) targets the address in command bits 15:0.
- R6: For kinds 1 and 2 with keep mask (bits 30:27) equal to zero, exactly one write of command bits 63:32 is issued, with no read.
- R7: For kinds 1 and 2 with a nonzero keep mask, a read of the same core and address comes first. The write that follows carries, for each byte i, the old byte when command bit 27+i is 1 and payload byte i otherwise.
- R8: A kind 1 or kind 2 command presented with cmd_wide low is dropped as in R2.
- R9: busy is high from the cycle after a non-dropped command is accepted until its write is accepted. cmd_valid is ignored while busy.
- R10: While req_valid is high and req_ready is low, req_valid, req_write, req_core, req_addr and req_wdata hold their values.
- R11: done pulses for one cycle in the cycle after the write is accepted, with busy already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_kind | input | 2 | 0 interrupt send, 1 mailbox send, 2 free-address send, 3 reserved |
| cmd_wide | input | 1 | Command arrived as a full 64-bit access |
| cmd_val | input | 64 | Command word |
| busy | output | 1 | A command sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| drop_evt | output | 1 | One-cycle pulse marking a dropped command |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Transaction request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_core | output | 10 | Destination core number |
| req_addr | output | 16 | Destination register address |
| req_wdata | output | 32 | Write data |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Returned read data |

## Verification
Some rules are checked by the assertions on every cycle. Requests stay stable while stalled, no request ever names an out-of-range core, an accepted read is followed by a wait with no request, done arrives only with the engine idle, drop_evt always comes with done, and busy rises only on a presented command. Other behaviour can only be shown by the bench's scenarios. This covers the address of each kind, the one-hot vector encoding, the byte-merge result for every keep mask, the exact count of reads and writes, and the rejection of narrow accesses and of a command injected mid-sequence. The bench covers these by sweeping all vectors, mailbox slots, masks and cores of a four-core configuration against arithmetic expectations.

// File: rtl/ipi_send_pkg.sv
package ipi_send_pkg;
    localparam int CMD_W        = 64;
    localparam int DATA_W       = 32;
    localparam int NBYTES       = DATA_W / 8;
    localparam int ADDR_W       = 16;
    localparam int CORE_FIELD_W = 10;
    localparam int CORE_LSB     = 16;
    localparam int MASK_LSB     = 27;
    localparam int PAYLOAD_LSB  = 32;
    localparam int VEC_W        = 5;

    typedef enum logic [1:0] {
        CMD_IPI  = 2'd0,
        CMD_MAIL = 2'd1,
        CMD_ANY  = 2'd2,
        CMD_RSVD = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ
    } send_state_e;

    typedef struct packed {
        logic                    drop;
        logic [CORE_FIELD_W-1:0] core;
        logic [ADDR_W-1:0]       addr;
        logic [NBYTES-1:0]       keep;
        logic [DATA_W-1:0]       wdata;
    } send_plan_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_send_pkg::*;
#(
    parameter int                NUM_CORES      = 4,
    parameter logic [ADDR_W-1:0] IPI_SET_ADDR   = 16'h1008,
    parameter logic [ADDR_W-1:0] MAIL_BASE_ADDR = 16'h1020
) (
    input  cmd_kind_e        kind,
    input  logic             wide,
    input  logic [CMD_W-1:0] val,
    output send_plan_t       plan
);
    localparam logic [CORE_FIELD_W:0] CORE_LIMIT = (CORE_FIELD_W + 1)'(NUM_CORES);

    logic [CORE_FIELD_W-1:0] core_f;
    logic                    core_bad;

    assign core_f   = val[CORE_LSB +: CORE_FIELD_W];
    assign core_bad = ({1'b0, core_f} >= CORE_LIMIT);

    always_comb begin
        plan.core  = core_f;
        plan.drop  = core_bad;
        plan.addr  = val[ADDR_W-1:0];
        plan.keep  = '0;
        plan.wdata = val[PAYLOAD_LSB +: DATA_W];
        unique case (kind)
            CMD_IPI: begin
                plan.addr  = IPI_SET_ADDR;
                plan.wdata = DATA_W'(1) << val[VEC_W-1:0];
            end
            CMD_MAIL: begin
                plan.addr = MAIL_BASE_ADDR + ADDR_W'({val[4:2], 2'b00});
                plan.keep = val[MASK_LSB +: NBYTES];
                plan.drop = core_bad | ~wide;
            end
            CMD_ANY: begin
                plan.keep = val[MASK_LSB +: NBYTES];
                plan.drop = core_bad | ~wide;
            end
            default: plan.drop = 1'b1;
        endcase
    end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge #(
    parameter int NBYTES = 4
) (
    input  logic [NBYTES-1:0]   keep,
    input  logic [8*NBYTES-1:0] old_word,
    input  logic [8*NBYTES-1:0] new_word,
    output logic [8*NBYTES-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
    end
endmodule

// File: rtl/ipi_send_engine.sv
module ipi_send_engine
    import ipi_send_pkg::*;
#(
    parameter int                NUM_CORES      = 4,
    parameter logic [ADDR_W-1:0] IPI_SET_ADDR   = 16'h1008,
    parameter logic [ADDR_W-1:0] MAIL_BASE_ADDR = 16'h1020
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_kind,
    input  logic        cmd_wide,
    input  logic [63:0] cmd_val,
    output logic        busy,
    output logic        done,
    output logic        drop_evt,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic [9:0]  req_core,
    output logic [15:0] req_addr,
    output logic [31:0] req_wdata,
    input  logic        rd_valid,
    input  logic [31:0] rd_data
);
    send_state_e             state, state_nx;
    send_plan_t              plan;
    logic                    accept;
    logic [CORE_FIELD_W-1:0] core_q;
    logic [ADDR_W-1:0]       addr_q;
    logic [NBYTES-1:0]       keep_q;
    logic [DATA_W-1:0]       new_q, wdata_q, merged;
    logic                    done_q, drop_q;

    ipi_cmd_decode #(
        .NUM_CORES     (NUM_CORES),
        .IPI_SET_ADDR  (IPI_SET_ADDR),
        .MAIL_BASE_ADDR(MAIL_BASE_ADDR)
    ) u_decode (
        .kind(cmd_kind_e'(cmd_kind)),
        .wide(cmd_wide),
        .val (cmd_val),
        .plan(plan)
    );

    ipi_byte_merge #(.NBYTES(NBYTES)) u_merge (
        .keep    (keep_q),
        .old_word(rd_data),
        .new_word(new_q),
        .merged  (merged)
    );

    assign accept = cmd_valid && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && !plan.drop)
                    state_nx = (plan.keep != '0) ? ST_RD_REQ : ST_WR_REQ;
            end
            ST_RD_REQ:  if (req_ready) state_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (rd_valid)  state_nx = ST_WR_REQ;
            ST_WR_REQ:  if (req_ready) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Captured command fields and completion pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q  <= '0;
            addr_q  <= '0;
            keep_q  <= '0;
            new_q   <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            drop_q  <= 1'b0;
        end else begin
            done_q <= (accept && plan.drop) || (state == ST_WR_REQ && req_ready);
            drop_q <= accept && plan.drop;
            if (accept && !plan.drop) begin
                core_q  <= plan.core;
                addr_q  <= plan.addr;
                keep_q  <= plan.keep;
                new_q   <= plan.wdata;
                wdata_q <= plan.wdata;
            end else if (state == ST_RD_WAIT && rd_valid) begin
                wdata_q <= merged;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        req_write = (state == ST_WR_REQ);
        req_core  = core_q;
        req_addr  = addr_q;
        req_wdata = wdata_q;
        done      = done_q;
        drop_evt  = drop_q;
    end
endmodule

// File: rtl/ipi_send_engine_chk.sv
module ipi_send_engine_chk #(
    parameter int NUM_CORES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        busy,
    input logic        done,
    input logic        drop_evt,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [9:0]  req_core,
    input logic [15:0] req_addr,
    input logic [31:0] req_wdata
);
    localparam logic [10:0] CORE_LIMIT = 11'(NUM_CORES);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_core)
                                       && $stable(req_addr) && $stable(req_wdata)));

    // R2
    core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_core} < CORE_LIMIT));

    // R2
    drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |-> (done && !req_valid));

    // R7
    read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |=> (busy && !req_valid));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
endmodule

bind ipi_send_engine ipi_send_engine_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .drop_evt (drop_evt),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_core (req_core),
    .req_addr (req_addr),
    .req_wdata(req_wdata)
);

// File: tb/ipi_send_engine_tb.sv
module ipi_send_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic        cmd_wide = 1'b1;
    logic [63:0] cmd_val = '0;
    logic        busy, done, drop_evt, req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [9:0]  req_core;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ipi_send_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_wide(cmd_wide), .cmd_val(cmd_val), .busy(busy), .done(done),
        .drop_evt(drop_evt), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_core(req_core), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [31:0] old_word(logic [9:0] core, logic [15:0] addr);
        return 32'hC300_0000 ^ {addr, 6'h2A, core} ^ (32'(core) * 32'h0101_0101);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic exec(input logic [1:0] kind, input bit wide, input logic [9:0] core,
                        input logic [15:0] low, input logic [3:0] mask, input logic [31:0] data,
                        input int stall, input bit inject, input string req);
        int nrd, nwr, cyc, wait_cnt;
        bit pend, drop_seen, exp_drop, done_next;
        logic [9:0]  wcore, rcore;
        logic [15:0] waddr, raddr, exp_addr;
        logic [31:0] wdata, exp_new, exp_data, old;
        logic [3:0]  exp_keep;
        nrd = 0; nwr = 0; cyc = 0; wait_cnt = 0; pend = 1'b0;
        wcore = '0; rcore = '0; waddr = '0; raddr = '0; wdata = '0;
        exp_drop = (core >= 10'd4) || (kind == 2'd3) || (kind != 2'd0 && !wide);
        exp_keep = (kind == 2'd0) ? 4'h0 : mask;
        case (kind)
            2'd0:    exp_addr = 16'h1008;
            2'd1:    exp_addr = 16'h1020 + (low & 16'h001C);
            default: exp_addr = low;
        endcase
        exp_new = (kind == 2'd0) ? (32'd1 << low[4:0]) : data;
        old = old_word(core, exp_addr);
        for (int b = 0; b < 4; b++)
            exp_data[8*b +: 8] = exp_keep[b] ? old[8*b +: 8] : exp_new[8*b +: 8];

        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_wide = wide;
        cmd_val = {data, 1'b0, mask, 1'b0, core, low};
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && cyc < 60) begin
            req_ready = 1'b0; rd_valid = 1'b0; cmd_valid = 1'b0;
            if (inject && cyc == 0 && busy) begin
                cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_wide = 1'b1;
                cmd_val = {32'h0, 5'h0, 1'b0, 10'd1, 16'd3};
            end
            if (pend) begin
                rd_valid = 1'b1; rd_data = old_word(rcore, raddr); pend = 1'b0;
            end else if (req_valid) begin
                if (wait_cnt >= stall) begin
                    req_ready = 1'b1; wait_cnt = 0;
                    if (req_write) begin
                        nwr++; wcore = req_core; waddr = req_addr; wdata = req_wdata;
                    end else begin
                        nrd++; rcore = req_core; raddr = req_addr; pend = 1'b1;
                    end
                end else wait_cnt++;
            end
            @(negedge clk);
            cyc++;
        end
        req_ready = 1'b0; rd_valid = 1'b0; cmd_valid = 1'b0;
        drop_seen = drop_evt;
        chk(done, req, "completion (hung)", 64'(done), 64'd1);
        chk(drop_seen == exp_drop, req, "drop_evt", 64'(drop_seen), 64'(exp_drop));
        chk(!busy, req, "busy with done", 64'(busy), 64'd0);
        if (exp_drop) begin
            chk(nrd == 0 && nwr == 0, req, "requests on drop", 64'(nrd * 16 + nwr), 64'd0);
        end else begin
            chk(nwr == 1, req, "write count", 64'(nwr), 64'd1);
            chk(nrd == ((exp_keep != 0) ? 1 : 0), req, "read count", 64'(nrd), 64'((exp_keep != 0) ? 1 : 0));
            if (nrd == 1)
                chk(rcore == core && raddr == exp_addr, "R7", "read target",
                    64'({rcore, raddr}), 64'({core, exp_addr}));
            chk(wcore == core, req, "write core", 64'(wcore), 64'(core));
            chk(waddr == exp_addr, req, "write address", 64'(waddr), 64'(exp_addr));
            chk(wdata == exp_data, req, "write data", 64'(wdata), 64'(exp_data));
        end
        @(negedge clk);
        done_next = done;
        chk(!done_next, "R11", "done single cycle", 64'(done_next), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !drop_evt && !req_valid, "R1", "reset outputs",
            64'({busy, done, drop_evt, req_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !drop_evt && !req_valid, "R1", "outputs after release",
            64'({busy, done, drop_evt, req_valid}), 64'd0);

        // R3: every vector on every core; keep mask set but ignored; upper low bits are noise
        for (int c = 0; c < 4; c++)
            for (int v = 0; v < 32; v++)
                exec(2'd0, (v % 2) == 0, 10'(c), 16'h05E0 | 16'(v), 4'(v), 32'hDEAD_0000 | 32'(v),
                     v % 3, 1'b0, "R3");

        // R4, R6, R7: every mailbox slot and mask on every core, noise in ignored low bits
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 8; s++)
                for (int m = 0; m < 16; m++)
                    exec(2'd1, 1'b1, 10'(c), 16'hA0C1 | 16'(s << 2), 4'(m),
                         32'h1122_3344 + 32'(s * 16 + m) * 32'h0102_0304, (s + m) % 3, 1'b0,
                         (m == 0) ? "R6" : "R7");

        // R5, R6, R7: free-address sends across the address range
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++)
                exec(2'd2, 1'b1, 10'(a % 4), 16'(a * 16'h1111 + 16'h0007), 4'(m),
                     32'h8765_4321 ^ 32'(a * 131 + m), m % 2, 1'b0, (m == 0) ? "R5" : "R7");

        // R2: out-of-range cores and the reserved kind
        for (int c = 4; c < 8; c++)
            for (int k = 0; k < 3; k++)
                exec(2'(k), 1'b1, 10'(c), 16'h0004, 4'h3, 32'hFFFF_FFFF, 0, 1'b0, "R2");
        exec(2'd1, 1'b1, 10'd1023, 16'h0008, 4'h0, 32'h1, 0, 1'b0, "R2");
        exec(2'd3, 1'b1, 10'd0, 16'h0008, 4'h0, 32'h1, 0, 1'b0, "R2");

        // R8: narrow mailbox and free-address accesses are dropped
        for (int c = 0; c < 4; c++) begin
            exec(2'd1, 1'b0, 10'(c), 16'h0010, 4'h0, 32'h5555_AAAA, 0, 1'b0, "R8");
            exec(2'd2, 1'b0, 10'(c), 16'h2000, 4'hF, 32'h5555_AAAA, 0, 1'b0, "R8");
        end

        // R9: command presented mid-sequence must not start a second transaction
        exec(2'd1, 1'b1, 10'd2, 16'h0014, 4'h5, 32'hCAFE_F00D, 2, 1'b1, "R9");
        exec(2'd2, 1'b1, 10'd3, 16'h3004, 4'h0, 32'h0BAD_BEEF, 3, 1'b1, "R9");

        // R10: long stalls on both read and write legs
        exec(2'd2, 1'b1, 10'd1, 16'h4444, 4'hA, 32'h0F0F_F0F0, 7, 1'b0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule